// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block guesses the next result an instruction will write to a register, from the results that instruction produced before. A direct-mapped table is indexed by the instruction address. Each entry keeps the most recent result, a candidate stride and a committed stride. The lookup port returns the most recent result plus the committed stride, with a hit flag that shows whether the entry has been trained.

The update port takes an instruction address and the actual result. Each update rewrites the candidate stride with the new difference. The committed stride changes only when that difference equals the candidate stride already held, that is, when the same step has occurred twice in a row. A single irregular value therefore moves the candidate stride but leaves predictions on the established stride. Lookups are combinational. Updates take effect at the rising clock edge. A parameter selects whether a lookup that meets an update to the same entry in the same cycle sees the old or the new contents.

Top module: `vp_stride_pred`

## Requirements
- R1: After reset every entry is untrained: lookups at any address return `lk_hit` = 0 until that entry is updated.
- R2: The entry is selected by address bits [ALIGN+IDX_W-1:ALIGN], which are bits 6:2 by default. There is no tag, so two addresses that agree in those bits share an entry. An update at one address leaves entries with a different index untrained.
- R3: The first update of an untrained entry marks it trained, stores the result and clears both strides, so the next lookup returns that result with `lk_hit` = 1.
- R4: For a trained entry the lookup returns the stored last result plus the committed stride, modulo 2^VAL_W.
- R5: Every update of a trained entry overwrites the candidate stride with the new result minus the stored last result, whether or not the committed stride changes.
- R6: The committed stride takes the new difference only when that difference equals the candidate stride held before the update. Otherwise it keeps its value. The stored last result is always replaced by the new result.
- R7: A constant sequence is predicted exactly once the entry has been trained.
- R8: When a lookup and an update address the same entry in one cycle, the lookup returns the pre-update prediction with FWD = 0 and the post-update prediction with FWD = 1.
- R9: A lookup of an untrained entry drives `lk_value` to 0.
- R10: Differences and predictions wrap modulo 2^VAL_W, so a sequence that crosses the top of the value range keeps its stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all entries |
| lk_pc | input | PC_W | Address of the instruction being predicted |
| lk_hit | output | 1 | Entry is trained and the prediction is usable |
| lk_value | output | VAL_W | Predicted result (0 when not hit) |
| up_en | input | 1 | Apply a training update this cycle |
| up_pc | input | PC_W | Address of the instruction that produced the result |
| up_value | input | VAL_W | Actual result used for training |

## Verification
A lookup and an update can target the same entry in the same clock cycle. This is the one case where the two ports interact. The bench provokes it by setting `lk_pc` equal to `up_pc` while `up_en` is high, both on a fixed entry and on every entry of a full-table sweep. It drives two copies of the predictor, one per FWD setting. It expects the pre-update prediction from the FWD = 0 copy and the post-update prediction from the FWD = 1 copy. Both expected values come from an arithmetic model of the two strides that the bench keeps for itself.

// File: rtl/vp_pkg.sv
package vp_pkg;
   // kind of training step applied to an entry
   typedef enum logic [0:0] {
      TRN_SEED  = 1'b0,   // entry untrained: seed last value, clear strides
      TRN_DELTA = 1'b1    // entry trained: two-delta stride update
   } trn_kind_e;

   // forwarding variants of the same-cycle lookup/update collision
   localparam bit FWD_OLD = 1'b0;
   localparam bit FWD_NEW = 1'b1;
endpackage

// File: rtl/vp_index.sv
module vp_index #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 5,
   parameter int ALIGN = 2
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   localparam int LSB = ALIGN;
   localparam int MSB = ALIGN + IDX_W - 1;

   if (MSB >= PC_W) begin : g_bad_slice
      $error("vp_index: index slice exceeds address width");
   end

   assign idx = pc[MSB:LSB];
endmodule

// File: rtl/vp_train.sv
module vp_train
   import vp_pkg::*;
#(
   parameter int VAL_W = 32
) (
   input  logic             old_vld,
   input  logic [VAL_W-1:0] old_last,
   input  logic [VAL_W-1:0] old_s1,
   input  logic [VAL_W-1:0] old_s2,
   input  logic [VAL_W-1:0] value,
   output trn_kind_e        kind,
   output logic [VAL_W-1:0] nxt_last,
   output logic [VAL_W-1:0] nxt_s1,
   output logic [VAL_W-1:0] nxt_s2
);
   logic [VAL_W-1:0] diff;
   logic             repeat_step;

   assign kind        = old_vld ? TRN_DELTA : TRN_SEED;
   assign diff        = value - old_last;
   assign repeat_step = (diff == old_s1);

   always_comb begin
      nxt_last = value;
      unique case (kind)
         TRN_SEED: begin
            nxt_s1 = '0;
            nxt_s2 = '0;
         end
         TRN_DELTA: begin
            nxt_s1 = diff;
            nxt_s2 = repeat_step ? diff : old_s2;
         end
         default: begin
            nxt_s1 = '0;
            nxt_s2 = '0;
         end
      endcase
   end
endmodule

// File: rtl/vp_table.sv
module vp_table #(
   parameter int VAL_W = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   // lookup read
   input  logic [IDX_W-1:0] ra_idx,
   output logic             ra_vld,
   output logic [VAL_W-1:0] ra_last,
   output logic [VAL_W-1:0] ra_s2,
   // update read
   input  logic [IDX_W-1:0] rb_idx,
   output logic             rb_vld,
   output logic [VAL_W-1:0] rb_last,
   output logic [VAL_W-1:0] rb_s1,
   output logic [VAL_W-1:0] rb_s2,
   // write
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VAL_W-1:0] wr_last,
   input  logic [VAL_W-1:0] wr_s1,
   input  logic [VAL_W-1:0] wr_s2
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [VAL_W-1:0] last_q [DEPTH];
   logic [VAL_W-1:0] s1_q   [DEPTH];
   logic [VAL_W-1:0] s2_q   [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic hit_wr;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[e]  <= 1'b0;
            last_q[e] <= '0;
            s1_q[e]   <= '0;
            s2_q[e]   <= '0;
         end else if (hit_wr) begin
            vld_q[e]  <= 1'b1;
            last_q[e] <= wr_last;
            s1_q[e]   <= wr_s1;
            s2_q[e]   <= wr_s2;
         end
      end
   end

   assign ra_vld  = vld_q[ra_idx];
   assign ra_last = last_q[ra_idx];
   assign ra_s2   = s2_q[ra_idx];
   assign rb_vld  = vld_q[rb_idx];
   assign rb_last = last_q[rb_idx];
   assign rb_s1   = s1_q[rb_idx];
   assign rb_s2   = s2_q[rb_idx];
endmodule

// File: rtl/vp_stride_pred.sv
module vp_stride_pred
   import vp_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int VAL_W = 32,
   parameter int IDX_W = 5,
   parameter int ALIGN = 2,
   parameter bit FWD   = FWD_OLD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  lk_pc,
   output logic             lk_hit,
   output logic [VAL_W-1:0] lk_value,
   input  logic             up_en,
   input  logic [PC_W-1:0]  up_pc,
   input  logic [VAL_W-1:0] up_value
);
   if (VAL_W < 2) begin : g_bad_val
      $error("vp_stride_pred: VAL_W must be at least 2");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("vp_stride_pred: IDX_W out of range 1..10");
   end
   if (ALIGN + IDX_W > PC_W) begin : g_bad_pc
      $error("vp_stride_pred: index does not fit in the address");
   end

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic             ra_vld, rb_vld;
   logic [VAL_W-1:0] ra_last, ra_s2;
   logic [VAL_W-1:0] rb_last, rb_s1, rb_s2;
   logic [VAL_W-1:0] nxt_last, nxt_s1, nxt_s2;
   trn_kind_e        trn_kind;

   vp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_idx_lk (
      .pc (lk_pc),
      .idx(lk_idx)
   );

   vp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_idx_up (
      .pc (up_pc),
      .idx(up_idx)
   );

   vp_table #(.VAL_W(VAL_W), .IDX_W(IDX_W)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (lk_idx),
      .ra_vld (ra_vld),
      .ra_last(ra_last),
      .ra_s2  (ra_s2),
      .rb_idx (up_idx),
      .rb_vld (rb_vld),
      .rb_last(rb_last),
      .rb_s1  (rb_s1),
      .rb_s2  (rb_s2),
      .wr_en  (up_en),
      .wr_idx (up_idx),
      .wr_last(nxt_last),
      .wr_s1  (nxt_s1),
      .wr_s2  (nxt_s2)
   );

   vp_train #(.VAL_W(VAL_W)) u_trn (
      .old_vld (rb_vld),
      .old_last(rb_last),
      .old_s1  (rb_s1),
      .old_s2  (rb_s2),
      .value   (up_value),
      .kind    (trn_kind),
      .nxt_last(nxt_last),
      .nxt_s1  (nxt_s1),
      .nxt_s2  (nxt_s2)
   );

   logic [VAL_W-1:0] pred_tab;
   assign pred_tab = ra_vld ? (ra_last + ra_s2) : '0;

   if (FWD == FWD_NEW) begin : g_fwd
      logic collide;
      assign collide  = up_en && (up_idx == lk_idx);
      assign lk_hit   = collide | ra_vld;
      assign lk_value = collide ? (nxt_last + nxt_s2) : pred_tab;
   end else begin : g_nofwd
      assign lk_hit   = ra_vld;
      assign lk_value = pred_tab;
   end
endmodule

// File: rtl/vp_stride_pred_chk.sv
module vp_stride_pred_chk #(
   parameter int PC_W  = 32,
   parameter int VAL_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PC_W-1:0]  lk_pc,
   input logic             lk_hit,
   input logic [VAL_W-1:0] lk_value,
   input logic             up_en,
   input logic [PC_W-1:0]  up_pc,
   input logic             old_vld,
   input logic [VAL_W-1:0] old_s1,
   input logic [VAL_W-1:0] old_s2,
   input logic [VAL_W-1:0] new_s2
);
   // R9: an untrained lookup drives a zero value
   p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_value == '0));

   // R3: an address just updated hits when looked up next cycle
   p_hit_after_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      up_en |=> ((lk_pc != $past(up_pc)) || lk_hit));

   // R6: the committed stride only ever moves to the held candidate stride
   p_s2_from_s1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && old_vld && (new_s2 != old_s2)) |-> (new_s2 == old_s1));

   // R4: without training, a steady lookup address gives a steady prediction
   p_pred_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !up_en |=> (!$stable(lk_pc) || up_en || ($stable(lk_value) && $stable(lk_hit))));

   // R1: no entry is trained while reset is held
   always @(posedge clk) begin
      p_reset_empty_r1: assert (rst_n || up_en || !lk_hit);
   end
endmodule

bind vp_stride_pred vp_stride_pred_chk #(.PC_W(PC_W), .VAL_W(VAL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lk_pc   (lk_pc),
   .lk_hit  (lk_hit),
   .lk_value(lk_value),
   .up_en   (up_en),
   .up_pc   (up_pc),
   .old_vld (rb_vld),
   .old_s1  (rb_s1),
   .old_s2  (rb_s2),
   .new_s2  (nxt_s2)
);

// File: tb/vp_stride_pred_tb.sv
`timescale 1ns/1ps
module vp_stride_pred_tb;
   localparam int PC_W  = 32;
   localparam int VAL_W = 32;
   localparam int IDX_W = 5;
   localparam int N     = 1 << IDX_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [PC_W-1:0]  lk_pc = '0;
   logic [PC_W-1:0]  up_pc = '0;
   logic [VAL_W-1:0] up_value = '0;
   logic             up_en = 1'b0;
   logic             hit_o, hit_f;
   logic [VAL_W-1:0] val_o, val_f;

   int n_chk = 0;
   int n_bad = 0;

   // bench model of the entries
   bit               m_vld  [N];
   logic [VAL_W-1:0] m_last [N];
   logic [VAL_W-1:0] m_s1   [N];
   logic [VAL_W-1:0] m_s2   [N];

   always #2.5 clk = ~clk;

   vp_stride_pred #(.FWD(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(hit_o), .lk_value(val_o),
      .up_en(up_en), .up_pc(up_pc), .up_value(up_value));

   vp_stride_pred #(.FWD(1'b1)) u_fwd (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(hit_f), .lk_value(val_f),
      .up_en(up_en), .up_pc(up_pc), .up_value(up_value));

   function automatic int ix(input logic [PC_W-1:0] pc);
      return int'(pc[IDX_W+1:2]);
   endfunction

   function automatic logic [VAL_W-1:0] m_pred(input int i);
      return m_vld[i] ? m_last[i] + m_s2[i] : '0;
   endfunction

   function automatic void m_train(input int i, input logic [VAL_W-1:0] v);
      logic [VAL_W-1:0] d;
      if (!m_vld[i]) begin
         m_vld[i] = 1'b1; m_s1[i] = '0; m_s2[i] = '0;
      end else begin
         d = v - m_last[i];
         if (d == m_s1[i]) m_s2[i] = d;
         m_s1[i] = d;
      end
      m_last[i] = v;
   endfunction

   task automatic check(input string req, input logic [VAL_W-1:0] act,
                        input logic [VAL_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one training update, committed at the next rising edge
   task automatic train(input logic [PC_W-1:0] pc, input logic [VAL_W-1:0] v);
      @(negedge clk);
      up_en = 1'b1; up_pc = pc; up_value = v;
      @(negedge clk);
      up_en = 1'b0;
      m_train(ix(pc), v);
   endtask

   // lookup on both copies against the model
   task automatic look(input string req, input logic [PC_W-1:0] pc);
      lk_pc = pc;
      #1;
      check(req, {31'd0, hit_o}, {31'd0, m_vld[ix(pc)]});
      check(req, val_o, m_pred(ix(pc)));
      check(req, val_f, m_pred(ix(pc)));
   endtask

   // lookup and update hitting the same entry in one cycle
   task automatic collide(input string req, input logic [PC_W-1:0] pc,
                          input logic [VAL_W-1:0] v);
      logic [VAL_W-1:0] pre;
      @(negedge clk);
      pre = m_pred(ix(pc));
      up_en = 1'b1; up_pc = pc; up_value = v; lk_pc = pc;
      m_train(ix(pc), v);
      #1;
      check(req, val_o, pre);
      check(req, val_f, m_pred(ix(pc)));
      check(req, {31'd0, hit_f}, 32'd1);
      @(negedge clk);
      up_en = 1'b0;
   endtask

   task automatic expect_val(input string req, input logic [PC_W-1:0] pc,
                             input logic [VAL_W-1:0] exp);
      lk_pc = pc;
      #1;
      check(req, val_o, exp);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_vld[i] = 1'b0; m_last[i] = '0; m_s1[i] = '0; m_s2[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R9: every entry untrained after reset
      for (int i = 0; i < N; i++) begin
         lk_pc = PC_W'(i) << 2;
         #1;
         check("R1", {31'd0, hit_o}, 32'd0);
         check("R9", val_o, 32'd0);
      end

      // R3, R4, R5, R6: stride training on address 0x100 (index 0)
      train(32'h100, 32'd10); expect_val("R3", 32'h100, 32'd10);
      train(32'h100, 32'd13); expect_val("R6", 32'h100, 32'd13);
      train(32'h100, 32'd16); expect_val("R4", 32'h100, 32'd19);
      train(32'h100, 32'd20); expect_val("R6", 32'h100, 32'd23);
      train(32'h100, 32'd30); expect_val("R5", 32'h100, 32'd33);
      train(32'h100, 32'd40); expect_val("R5", 32'h100, 32'd50);

      // R2: aliasing address shares the entry; neighbour stays untrained
      expect_val("R2", 32'h180, 32'd50);
      lk_pc = 32'h104; #1;
      check("R2", {31'd0, hit_o}, 32'd0);

      // R7: constant sequence on address 0x208
      train(32'h208, 32'd7); expect_val("R7", 32'h208, 32'd7);
      train(32'h208, 32'd7); expect_val("R7", 32'h208, 32'd7);
      train(32'h208, 32'd7); expect_val("R7", 32'h208, 32'd7);

      // R10: crossing the top of the range
      train(32'h30c, 32'hFFFF_FFFE);
      train(32'h30c, 32'hFFFF_FFFF);
      train(32'h30c, 32'h0000_0000); expect_val("R10", 32'h30c, 32'h0000_0001);
      train(32'h30c, 32'h0000_0001); expect_val("R10", 32'h30c, 32'h0000_0002);

      // R8: same-cycle collision on trained entry 0 (pre 50, post 70)
      collide("R8", 32'h100, 32'd60);
      check("R8", m_pred(0), 32'd70);

      // sweep: every entry, strided sequences with a glitch and collisions
      for (int i = 0; i < N; i++) begin
         logic [PC_W-1:0] pc;
         logic [VAL_W-1:0] base, step;
         pc   = (PC_W'(i) << 2) + 32'h4000;
         base = VAL_W'(i) * 32'h0101_0101;
         step = (i % 3 == 0) ? -VAL_W'(i + 1) : VAL_W'(i * 7);
         for (int k = 0; k < 8; k++) begin
            logic [VAL_W-1:0] v;
            v = base + VAL_W'(k) * step;
            if (k == 4) v = v ^ 32'h0000_5A5A;
            if (k == 6) collide("R8", pc, v);
            else train(pc, v);
            look((k < 2) ? "R3" : "R6", pc);
         end
      end

      // R1: reset again clears trained entries
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look("R1", 32'h100);
      look("R1", 32'h4008);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule